// File: doc/BRIEF.md
# Pixel Photon Counter Array with Word-Serial Readout

This block holds one small counter per detector pixel. Each pixel delivers a one-cycle detect pulse per photon, and its counter adds one for each pulse. A period timer, set through a plain input, marks the end of every counting frame. At that edge all counters are copied into a holding bank and restarted in the same cycle. The held frame then leaves the block as a valid/ready stream, one count word per beat, while the counters are already collecting the next frame. This lets a slow serial readout keep pace with a large array.

An alternating mode supports background subtraction. Periods alternate between counting up and counting down, and a frame is captured only after each up/down pair. A steady background rate therefore cancels in the captured value.

Stream rules: a beat transfers on a rising edge with `out_valid` and `out_ready` both high. While a beat is stalled, its word, index and flags hold still. The one exception is an overrun, which replaces the stalled frame. Back-pressure never pauses the counters or the period timer.

Top module: `pixel_count_serializer`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` and `overrun` are low.
- R2: In plain mode (`alt_mode` low), each pixel's captured word equals the number of cycles in that frame in which its pulse input was high.
- R3: A period lasts `period_len`+1 clock cycles. In plain mode a capture ends every period, and `out_valid` rises in the cycle after the capture.
- R4: Counts are two's complement, CW bits wide. Counting up stops at 2^(CW-1)-1 and does not wrap.
- R5: A pulse that arrives in the capture cycle is not part of the captured frame. It becomes the first count, 1, of the new frame.
- R6: A frame leaves as NPIX beats with `out_idx` running 0 to NPIX-1. `out_first` is high only on index 0 and `out_last` only on index NPIX-1. After the last beat is accepted, `out_valid` drops.
- R7: While `out_valid` is high and `out_ready` is low, `out_count` and `out_idx` stay unchanged, unless an overrun occurs.
- R8: If a capture occurs while a frame is still unsent, `overrun` pulses high for one cycle in the next cycle. The unsent frame is dropped, and the new frame starts at index 0.
- R9: In alternating mode, periods alternate between counting up and counting down, starting with up. A capture happens only at the end of a down period, so each word is the up hits minus the down hits. A pulse in a period's final cycle belongs to the period that follows.
- R10: Counting down stops at -2^(CW-1) and does not wrap.
- R11: A capture in the same cycle as the acceptance of a frame's last beat is not an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_len | input | PW | Period length minus one, in cycles |
| alt_mode | input | 1 | Enables alternating up/down periods |
| photon | input | NPIX | One detect pulse bit per pixel |
| out_valid | output | 1 | Stream word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_count | output | CW | Captured count, two's complement |
| out_idx | output | IW | Pixel index of the word |
| out_first | output | 1 | First word of a frame |
| out_last | output | 1 | Last word of a frame |
| overrun | output | 1 | One-cycle pulse: an unsent frame was dropped |

## Verification
The bench goes after pulses that land exactly on the capture edge. A design that cleared to zero would lose those pulses, and one that captured after counting would put them in the wrong frame. It drives every pixel on every cycle to reach both saturation limits, which a wrapping counter would turn into small or sign-flipped words. It sets a period whose capture falls on the final accepted beat, where an overly cautious design would flag a false overrun. It also uses short periods with throttled ready to force real overruns, where a design that queued or merged frames would emit stale indices or missing restarts.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic {PH_UP = 1'b0, PH_DOWN = 1'b1} phase_t;
endpackage

// File: rtl/pcs_period_timer.sv
module pcs_period_timer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] period_len,
  input  logic          alt_mode,
  output logic          sample,
  output logic          count_down
);
  import pcs_pkg::*;

  logic [PW-1:0] tick;
  phase_t        phase;
  logic          wrap;

  assign wrap       = (tick >= period_len);
  assign sample     = wrap && (!alt_mode || phase == PH_DOWN);
  // a pulse in the final cycle of a period is credited to the next period
  assign count_down = alt_mode && (wrap ? (phase == PH_UP) : (phase == PH_DOWN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick  <= '0;
      phase <= PH_UP;
    end else begin
      tick <= wrap ? '0 : tick + PW'(1);
      if (!alt_mode)
        phase <= PH_UP;
      else if (wrap)
        phase <= (phase == PH_UP) ? PH_DOWN : PH_UP;
    end
  end
endmodule

// File: rtl/pcs_pixel_counter.sv
module pcs_pixel_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic          clear,
  input  logic          down,
  output logic [CW-1:0] value
);
  localparam logic [CW-1:0] TOP = {1'b0, {(CW-1){1'b1}}};
  localparam logic [CW-1:0] BOT = {1'b1, {(CW-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clear) begin
      value <= {{(CW-1){1'b0}}, hit};
    end else if (hit) begin
      if (down) begin
        if (value != BOT) value <= value - CW'(1);
      end else begin
        if (value != TOP) value <= value + CW'(1);
      end
    end
  end
endmodule

// File: rtl/pcs_readout.sv
module pcs_readout #(
  parameter int NPIX = 4,
  parameter int CW   = 8,
  parameter int IW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample,
  input  logic [NPIX*CW-1:0] counts,
  input  logic               out_ready,
  output logic               out_valid,
  output logic [CW-1:0]      out_count,
  output logic [IW-1:0]      out_idx,
  output logic               out_first,
  output logic               out_last,
  output logic               overrun
);
  localparam logic [IW-1:0] LAST = IW'(NPIX - 1);

  logic [CW-1:0] hold [NPIX];
  logic          busy;
  logic [IW-1:0] idx;
  logic          xfer;
  logic          done;

  assign xfer = busy && out_ready;
  assign done = xfer && (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      idx     <= '0;
      overrun <= 1'b0;
      for (int i = 0; i < NPIX; i++) hold[i] <= '0;
    end else begin
      overrun <= sample && busy && !done;
      if (sample) begin
        for (int i = 0; i < NPIX; i++) hold[i] <= counts[i*CW +: CW];
        busy <= 1'b1;
        idx  <= '0;
      end else if (xfer) begin
        if (idx == LAST) busy <= 1'b0;
        else             idx  <= idx + IW'(1);
      end
    end
  end

  assign out_valid = busy;
  assign out_count = hold[idx];
  assign out_idx   = idx;
  assign out_first = (idx == '0);
  assign out_last  = (idx == LAST);
endmodule

// File: rtl/pixel_count_serializer.sv
module pixel_count_serializer #(
  parameter int NPIX = 8,
  parameter int CW   = 6,
  parameter int PW   = 16,
  localparam int IW  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PW-1:0]   period_len,
  input  logic            alt_mode,
  input  logic [NPIX-1:0] photon,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [CW-1:0]   out_count,
  output logic [IW-1:0]   out_idx,
  output logic            out_first,
  output logic            out_last,
  output logic            overrun
);
  logic               sample_w;
  logic               down_w;
  logic [NPIX*CW-1:0] counts_flat;

  pcs_period_timer #(.PW(PW)) u_timer (
    .clk(clk), .rst_n(rst_n), .period_len(period_len), .alt_mode(alt_mode),
    .sample(sample_w), .count_down(down_w)
  );

  for (genvar g = 0; g < NPIX; g++) begin : g_pix
    pcs_pixel_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .hit(photon[g]), .clear(sample_w),
      .down(down_w), .value(counts_flat[g*CW +: CW])
    );
  end

  pcs_readout #(.NPIX(NPIX), .CW(CW), .IW(IW)) u_rd (
    .clk(clk), .rst_n(rst_n), .sample(sample_w), .counts(counts_flat),
    .out_ready(out_ready), .out_valid(out_valid), .out_count(out_count),
    .out_idx(out_idx), .out_first(out_first), .out_last(out_last),
    .overrun(overrun)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int CW = 6,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample,
  input logic          out_valid,
  input logic          out_ready,
  input logic [CW-1:0] out_count,
  input logic [IW-1:0] out_idx,
  input logic          out_first,
  input logic          out_last,
  input logic          overrun
);
  always @(negedge clk) begin
    if (!rst_n) assert_idle_in_reset_R1: assert (!out_valid && !overrun);
  end

  assert_frame_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> out_valid && out_first && out_idx == '0);

  assert_index_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last && !sample |=> out_idx == $past(out_idx) + IW'(1));

  assert_drop_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && !sample |=> !out_valid);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !sample |=> out_valid && $stable(out_count) && $stable(out_idx));

  assert_overrun_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sample && out_valid && !(out_ready && out_last) |=> overrun);

  assert_no_false_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sample && out_valid && out_ready && out_last |=> !overrun);
endmodule

bind pixel_count_serializer pcs_checker #(.CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample(sample_w), .out_valid(out_valid),
  .out_ready(out_ready), .out_count(out_count), .out_idx(out_idx),
  .out_first(out_first), .out_last(out_last), .overrun(overrun)
);

// File: tb/sim_pixel_count_serializer.sv
module sim_pixel_count_serializer;
  localparam int N = 4, CW = 5, PW = 8, IW = 2;
  localparam int TOPV = 15, BOTV = -16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [PW-1:0] period_len = '0;
  logic          alt_mode = 1'b0;
  logic [N-1:0]  photon = '0;
  logic          out_valid, out_ready, out_first, out_last, overrun;
  logic [CW-1:0] out_count;
  logic [IW-1:0] out_idx;

  pixel_count_serializer #(.NPIX(N), .CW(CW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .period_len(period_len), .alt_mode(alt_mode),
    .photon(photon), .out_valid(out_valid), .out_ready(out_ready),
    .out_count(out_count), .out_idx(out_idx), .out_first(out_first),
    .out_last(out_last), .overrun(overrun)
  );

  int checks = 0, errors = 0;
  string sec = "R2";
  int per = 0;
  bit alt = 0;
  // reference model state
  int m_tick = 0, m_phase = 0, m_idx = 0;
  int m_cnt[N], m_hold[N];
  bit m_busy = 0, m_ovr = 0;
  bit pv_stall = 0;
  int pv_cnt = 0, pv_idx = 0;
  int seen_max, seen_min, ovr_seen, not_one, beats;
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit m_wrap();
    return m_tick >= per;
  endfunction

  function automatic bit m_down();
    return alt && (m_wrap() ? (m_phase == 0) : (m_phase == 1));
  endfunction

  task automatic stats_clear();
    seen_max = -100; seen_min = 100; ovr_seen = 0; not_one = 0; beats = 0;
  endtask

  task automatic step(input logic [N-1:0] ph, input bit rdy);
    bit wrap, smp, dn, xfer, fin;
    int v;
    // compare outputs with the model (state after the previous edge)
    chk(out_valid == m_busy, "R3 valid", out_valid, m_busy);
    chk(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
    if (overrun) ovr_seen++;
    if (m_busy && out_valid) begin
      v = $signed(out_count);
      chk(int'(out_idx) == m_idx, "R6 index", out_idx, m_idx);
      chk(out_first == (m_idx == 0), "R6 first", out_first, m_idx == 0);
      chk(out_last == (m_idx == N-1), "R6 last", out_last, m_idx == N-1);
      chk(v == m_hold[m_idx], sec, v, m_hold[m_idx]);
      if (pv_stall) begin
        chk(v == pv_cnt, "R7 word held", v, pv_cnt);
        chk(int'(out_idx) == pv_idx, "R7 index held", out_idx, pv_idx);
      end
      if (rdy) begin
        beats++;
        if (v > seen_max) seen_max = v;
        if (v < seen_min) seen_min = v;
        if (v != 1) not_one++;
      end
    end
    // drive next inputs
    photon = ph; out_ready = rdy; period_len = PW'(per); alt_mode = alt;
    // advance model across the coming edge
    wrap = m_wrap();
    smp  = wrap && (!alt || m_phase == 1);
    dn   = m_down();
    xfer = m_busy && rdy;
    fin  = xfer && (m_idx == N-1);
    pv_stall = m_busy && !rdy && !smp;
    pv_cnt = m_busy ? m_hold[m_idx] : 0;
    pv_idx = m_idx;
    m_ovr = smp && m_busy && !fin;
    if (smp) begin
      for (int i = 0; i < N; i++) m_hold[i] = m_cnt[i];
      m_busy = 1; m_idx = 0;
    end else if (xfer) begin
      if (m_idx == N-1) m_busy = 0; else m_idx++;
    end
    for (int i = 0; i < N; i++) begin
      if (smp) m_cnt[i] = ph[i] ? 1 : 0;
      else if (ph[i]) begin
        if (dn) begin if (m_cnt[i] > BOTV) m_cnt[i]--; end
        else    begin if (m_cnt[i] < TOPV) m_cnt[i]++; end
      end
    end
    m_tick  = wrap ? 0 : m_tick + 1;
    m_phase = !alt ? 0 : (wrap ? 1 - m_phase : m_phase);
    @(negedge clk);
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_hold[i] = 0; end
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 valid in reset", out_valid, 0);
    chk(!overrun, "R1 overrun in reset", overrun, 0);
    rst_n = 1'b1;
    chk(!out_valid, "R1 valid after reset", out_valid, 0);

    // R2 plain counting with scattered pulses, always ready
    sec = "R2 count"; per = 11; alt = 0; stats_clear();
    for (int c = 0; c < 300; c++) begin lf = nxt(lf); step(lf[N-1:0] & lf[N+3:4], 1'b1); end

    // R7 throttled ready, long period
    sec = "R7 count"; per = 40; stats_clear();
    for (int c = 0; c < 400; c++) begin lf = nxt(lf); step(lf[N-1:0], lf[9] & lf[2]); end

    // R4 saturation upward
    sec = "R4 count"; per = 25; stats_clear();
    for (int c = 0; c < 200; c++) step('1, 1'b1);
    chk(seen_max == TOPV, "R4 top limit", seen_max, TOPV);

    // R5 pulses only on the capture cycle
    sec = "R5 count"; per = 5; stats_clear();
    for (int c = 0; c < 20; c++) step(m_wrap() ? '1 : '0, 1'b1);
    stats_clear();
    for (int c = 0; c < 200; c++) step(m_wrap() ? '1 : '0, 1'b1);
    chk(not_one == 0 && beats > 0, "R5 capture pulse counts as 1", not_one, 0);

    // R11 capture coincides with last beat acceptance
    sec = "R11 count"; per = 3; stats_clear();
    for (int c = 0; c < 20; c++) begin lf = nxt(lf); step(lf[N-1:0], 1'b1); end
    stats_clear();
    for (int c = 0; c < 200; c++) begin lf = nxt(lf); step(lf[N-1:0], 1'b1); end
    chk(ovr_seen == 0, "R11 no overrun", ovr_seen, 0);

    // R8 forced overruns
    sec = "R8 count"; per = 2; stats_clear();
    for (int c = 0; c < 200; c++) begin lf = nxt(lf); step(lf[N-1:0], lf[5] & lf[11]); end
    chk(ovr_seen > 0, "R8 overrun seen", ovr_seen, 1);

    // R9 alternating mode with random pulses
    sec = "R9 count"; per = 7; alt = 1; stats_clear();
    for (int c = 0; c < 400; c++) begin lf = nxt(lf); step(lf[N-1:0] | lf[N+6:7], 1'b1); end

    // R10 pulses only in down periods
    sec = "R10 count"; per = 30; stats_clear();
    for (int c = 0; c < 300; c++) step(m_down() ? '1 : '0, 1'b1);
    chk(seen_min == BOTV, "R10 bottom limit", seen_min, BOTV);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule